// File: doc/BRIEF.md
# Prescaled Match Timer

A free-running 32-bit timer whose count advances once every (prescale + 1) clocks while it is enabled. A prescale counter divides the clock: it counts up from zero, and when it reaches the programmed prescale value the main count advances and the prescale counter returns to zero.

The timer compares its count against two match values. Each match has three actions, and a control word turns each one on or off. The first action raises a sticky interrupt flag. The second reloads the count with zero. The third halts the timer and clears its enable bit. All configuration goes through a small register port with a synchronous write and a combinational read. The count, the prescale count and the flags are also available as outputs.

Top module: `prescaled_match_timer`

## Requirements
- R1: While enabled, the prescale count steps 0,1,..,P and the count advances by one on each clock where the prescale count equals P. The count therefore advances every P+1 clocks.
- R2: Register map on `addr_i` (3 bits):
  - 0: control. Bit 0 is enable and bit 1 is counter reset.
  - 1: prescale value P.
  - 2: match value 0.
  - 3: match value 1.
  - 4: match control.
  - 5: interrupt flags.
  - 6: count, read only.
  - 7: prescale count, read only.
  Writes take effect at the clock edge, and reads are combinational.
- R3: Match control layout:
  - bit 0: interrupt on match 0.
  - bit 1: reset on match 0.
  - bit 2: stop on match 0.
  - bit 3: interrupt on match 1.
  - bit 4: reset on match 1.
  - bit 5: stop on match 1.
  Bits above 5 read back as 0.
- R4: A match is evaluated only on a clock where the count would advance. A match with its interrupt bit set raises its flag (bit 0 for match 0, bit 1 for match 1). With that bit clear, no flag is raised.
- R5: A match with its reset bit set loads 0 in place of the increment, so the count wraps from the match value to 0.
- R6: A match with its stop bit set clears the enable bit and zeroes the prescale count. The count holds its value, or takes 0 if a reset action also fires. The stop clearing enable wins over a write to control on the same clock.
- R7: Flags are sticky. Writing 1 to a flag bit at address 5 clears it, and writing 0 has no effect. A flag set on the same clock wins over the clear. `irq_o` is the OR of the flags.
- R8: While control bit 1 is set, the count and the prescale count are held at zero.
- R9: After reset, every register, both counters and both flags are zero.
- R10: When both matches fire on the same clock, the enabled actions of both apply, and a stop takes precedence over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| count_o | output | 32 | Timer count |
| pcount_o | output | 32 | Prescale count |
| irq_flags_o | output | 2 | Sticky match flags |
| irq_o | output | 1 | OR of the flags |

## Verification
A write lands at the clock edge where `we_i` is sampled. The first enabled clock after the enabling write is the next edge. So after that edge and N more edges, the count equals the number of prescale wraps in N clocks, adjusted for matches. The bench therefore samples N edges after the enable, at the falling edge. Flags, the enable bit and the counter values all change on the same edge as the matching tick, so a read at the following falling edge sees them. Reads are combinational, and they are taken between edges without advancing the clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W     = 32;
  localparam int unsigned NUM_MATCH = 2;
  localparam int unsigned ACT_W     = 3;
  localparam int unsigned MCTL_W    = NUM_MATCH * ACT_W;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_PRESC  = 3'd1,
    A_MATCH0 = 3'd2,
    A_MATCH1 = 3'd3,
    A_MCTL   = 3'd4,
    A_IRQ    = 3'd5,
    A_COUNT  = 3'd6,
    A_PCOUNT = 3'd7
  } tmr_addr_e;

  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } match_act_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] pcount_o,
  output logic         tick_o
);
  logic [W-1:0] pc_q;

  assign tick_o   = run_i && !clr_i && (pc_q == limit_i);
  assign pcount_o = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (clr_i)    pc_q <= '0;
    else if (tick_o)   pc_q <= '0;
    else if (run_i)    pc_q <= pc_q + 1'b1;
  end

  assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> pc_q == '0);
  assert_clr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pc_q == '0);
  assert_idle_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import tmr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         tick_i,
  input  logic [W-1:0] count_i,
  input  logic [W-1:0] value_i,
  input  match_act_t   act_i,
  output logic         irq_o,
  output logic         rst_o,
  output logic         stop_o
);
  logic hit;
  assign hit    = tick_i && (count_i == value_i);
  assign irq_o  = hit && act_i.irq;
  assign rst_o  = hit && act_i.rst;
  assign stop_o = hit && act_i.stop;
endmodule

// File: rtl/prescaled_match_timer.sv
module prescaled_match_timer
  import tmr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [2:0]           addr_i,
  input  logic [TMR_W-1:0]     wdata_i,
  output logic [TMR_W-1:0]     rdata_o,
  output logic [TMR_W-1:0]     count_o,
  output logic [TMR_W-1:0]     pcount_o,
  output logic [NUM_MATCH-1:0] irq_flags_o,
  output logic                 irq_o
);
  logic                 en_q, crst_q;
  logic [TMR_W-1:0]     presc_q, tc_q;
  logic [TMR_W-1:0]     mval_q [NUM_MATCH];
  logic [MCTL_W-1:0]    mctl_q;
  logic [NUM_MATCH-1:0] flag_q, m_irq, m_rst, m_stop;
  logic                 tick, any_rst, any_stop;

  wire wr_ctrl = we_i && (addr_i == A_CTRL);
  wire wr_irq  = we_i && (addr_i == A_IRQ);

  tmr_prescaler #(.W(TMR_W)) u_presc (
    .clk_i, .rst_ni, .clr_i(crst_q), .run_i(en_q),
    .limit_i(presc_q), .pcount_o, .tick_o(tick)
  );

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_match
    tmr_match #(.W(TMR_W)) u_match (
      .tick_i(tick), .count_i(tc_q), .value_i(mval_q[i]),
      .act_i(match_act_t'(mctl_q[i*ACT_W +: ACT_W])),
      .irq_o(m_irq[i]), .rst_o(m_rst[i]), .stop_o(m_stop[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mval_q[i] <= '0;
      else if (we_i && (addr_i == 3'(A_MATCH0 + i))) mval_q[i] <= wdata_i;
    end

    // set wins over write-one-to-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  flag_q[i] <= 1'b0;
      else if (m_irq[i])            flag_q[i] <= 1'b1;
      else if (wr_irq && wdata_i[i]) flag_q[i] <= 1'b0;
    end

    assert_flag_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_q[i]) |-> $past(wr_irq && wdata_i[i]));
    assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_irq[i] |=> flag_q[i]);
  end

  assign any_rst  = |m_rst;
  assign any_stop = |m_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      crst_q  <= 1'b0;
      presc_q <= '0;
      mctl_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[0];
        crst_q <= wdata_i[1];
      end
      if (any_stop) en_q <= 1'b0;
      if (we_i && addr_i == A_PRESC) presc_q <= wdata_i;
      if (we_i && addr_i == A_MCTL)  mctl_q  <= wdata_i[MCTL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tc_q <= '0;
    else if (crst_q)               tc_q <= '0;
    else if (tick && any_rst)      tc_q <= '0;
    else if (tick && !any_stop)    tc_q <= tc_q + 1'b1;
  end

  always_comb begin
    unique case (tmr_addr_e'(addr_i))
      A_CTRL:   rdata_o = TMR_W'({crst_q, en_q});
      A_PRESC:  rdata_o = presc_q;
      A_MATCH0: rdata_o = mval_q[0];
      A_MATCH1: rdata_o = mval_q[1];
      A_MCTL:   rdata_o = TMR_W'(mctl_q);
      A_IRQ:    rdata_o = TMR_W'(flag_q);
      A_COUNT:  rdata_o = tc_q;
      A_PCOUNT: rdata_o = pcount_o;
      default:  rdata_o = '0;
    endcase
  end

  assign count_o     = tc_q;
  assign irq_flags_o = flag_q;
  assign irq_o       = |flag_q;

  assert_advance_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !any_rst && !any_stop) |=> tc_q == $past(tc_q) + 1'b1);
  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rst |=> tc_q == '0);
  assert_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stop |=> !en_q && pcount_o == '0);
  assert_stop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_stop && !any_rst) |=> $stable(tc_q));
  assert_crst_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_q |=> tc_q == '0);
  assert_irq_or_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (flag_q != '0));
endmodule

// File: tb/prescaled_match_timer_bench.sv
module prescaled_match_timer_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] pr;
    logic [31:0] m0;
    logic [31:0] m1;
    logic [5:0]  mctl;
    logic [15:0] n;
    logic [31:0] tc;
    logic [31:0] pc;
    logic [1:0]  flags;
    logic        en;
  } vec_t;

  // R1 free run, R5 wrap, R6 stop, R4 irq gating, R10 coincident matches
  localparam vec_t VECS [7] = '{
    '{32'd0, 32'd0, 32'd0, 6'h00, 16'd10, 32'd10, 32'd0, 2'b00, 1'b1},
    '{32'd3, 32'd0, 32'd0, 6'h00, 16'd10, 32'd2,  32'd2, 2'b00, 1'b1},
    '{32'd0, 32'd5, 32'd0, 6'h03, 16'd10, 32'd4,  32'd0, 2'b01, 1'b1},
    '{32'd0, 32'd0, 32'd4, 6'h28, 16'd10, 32'd4,  32'd0, 2'b10, 1'b0},
    '{32'd1, 32'd3, 32'd3, 6'h0A, 16'd20, 32'd2,  32'd0, 2'b10, 1'b1},
    '{32'd0, 32'd2, 32'd2, 6'h1C, 16'd8,  32'd0,  32'd0, 2'b10, 1'b0},
    '{32'd0, 32'd3, 32'd0, 6'h02, 16'd9,  32'd1,  32'd0, 2'b00, 1'b1}
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, count, pcount;
  logic [1:0]  flags;
  logic        irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prescaled_match_timer u_prescaled_match_timer (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .count_o(count), .pcount_o(pcount),
    .irq_flags_o(flags), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state
    check("R9 count", count, 0);
    check("R9 pcount", pcount, 0);
    check("R9 flags", {30'd0, flags}, 0);
    rd(3'd0, r); check("R9 ctrl", r, 0);
    rd(3'd4, r); check("R9 mctl", r, 0);

    foreach (VECS[i]) begin
      wr(3'd0, 32'd2);
      wr(3'd1, VECS[i].pr);
      wr(3'd2, VECS[i].m0);
      wr(3'd3, VECS[i].m1);
      wr(3'd4, {26'd0, VECS[i].mctl});
      wr(3'd5, 32'd3);
      wr(3'd0, 32'd1);
      repeat (VECS[i].n) @(posedge clk);
      @(negedge clk);
      check($sformatf("R1 R5 R10 count vec%0d", i), count, VECS[i].tc);
      check($sformatf("R1 pcount vec%0d", i), pcount, VECS[i].pc);
      check($sformatf("R4 flags vec%0d", i), {30'd0, flags}, {30'd0, VECS[i].flags});
      check($sformatf("R7 irq vec%0d", i), {31'd0, irq}, {31'd0, |VECS[i].flags});
      rd(3'd0, r);
      check($sformatf("R6 enable vec%0d", i), {31'd0, r[0]}, {31'd0, VECS[i].en});
    end

    // R7: zero write leaves flags, one clears only that bit
    wr(3'd0, 32'd2);
    wr(3'd1, 32'd0); wr(3'd2, 32'd1); wr(3'd3, 32'd1); wr(3'd4, 32'h09);
    wr(3'd5, 32'd3);
    wr(3'd0, 32'd1);
    repeat (3) @(posedge clk); @(negedge clk);
    wr(3'd0, 32'd0);
    check("R7 both set", {30'd0, flags}, 32'd3);
    wr(3'd5, 32'd0);
    check("R7 zero write no effect", {30'd0, flags}, 32'd3);
    wr(3'd5, 32'd1);
    check("R7 clear bit0", {30'd0, flags}, 32'd2);
    check("R7 irq still high", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'd2);
    check("R7 irq low", {31'd0, irq}, 32'd0);

    // R8 counter reset holds while enabled
    wr(3'd4, 32'd0);
    wr(3'd0, 32'd3);
    repeat (5) @(posedge clk); @(negedge clk);
    check("R8 count held", count, 0);
    check("R8 pcount held", pcount, 0);
    rd(3'd0, r); check("R2 ctrl readback", r, 3);

    // R3 / R2 readback
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, r); check("R3 mctl width", r, 32'h3F);
    wr(3'd2, 32'hDEAD_BEEF);
    rd(3'd2, r); check("R2 match0 readback", r, 32'hDEAD_BEEF);
    rd(3'd1, r); check("R2 prescale readback", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule